// File: doc/BRIEF.md
# Circular CORDIC Rotate/Vector Engine

This block is an iterative shift-and-add engine for circular-coordinate CORDIC. It runs in one of two directions. In rotation mode it turns the vector (X, Y) through the angle Z. With X preset to the reciprocal of the gain and Y at zero, this gives cosine and sine. With any (X, Y) pair it gives a Park-style frame rotation. In vectoring mode it turns (X, Y) onto the positive X axis. The result is the scaled magnitude in X and the accumulated angle in Z.

Software-style register writes load three operands. Each operand is a 24-bit two's-complement value held in bits 31:8 of a 32-bit word. The same layout is used for the three result words. A computation starts in one of two ways. With auto-start enabled, it starts on the write of the X operand, so Y and Z are written first. With auto-start disabled, it starts on a separate start pulse. Each computation takes one micro-rotation per clock for 24 clocks. The CORDIC gain is not removed from the X and Y results.

Top module: `rotvec_cordic`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `busy` and `done` are low and all three result words read zero.
- R2: Operands are taken from `wr_data[31:8]` as signed 24-bit values and `wr_data[7:0]` is ignored. Each result word carries its signed 24-bit value in bits 31:8, with bits 7:0 always zero.
- R3: With `cfg_mode` = 2'b01, `cfg_autostart` = 1 and the block idle, a clock edge with `wr_x` high starts a computation. It uses the X value being written and the Y and Z values written earlier. `busy` is high in the next cycle.
- R4: With `cfg_autostart` = 0, writing X does not start a computation. A `start` pulse on an idle block with `cfg_mode` = 2'b01 does start one.
- R5: With `cfg_mode` other than 2'b01, neither an X write nor `start` starts a computation, and the result words are left unchanged.
- R6: `cfg_rotate` = 1 selects rotation, and it is sampled at the start edge. The angle is z·π/2^23, valid for |angle| up to 99 degrees. The results are X = K(x·cos − y·sin) and Y = K(x·sin + y·cos), with K ≈ 1.646760, and Z reaches zero. Each result is within 128 LSB.
- R7: `cfg_rotate` = 0 selects vectoring, valid for x > 0. The results are X = K·sqrt(x² + y²), Y near zero and Z = z + atan2(y, x)·2^23/π. Each result is within 128 LSB.
- R8: `busy` stays high for exactly 24 cycles after the start edge. `done` rises on the 24th clock edge after the start edge, well within a 62-clock budget.
- R9: The start edge clears `done`. `done` then stays high from completion until the next start. The result words change only on the completion edge.
- R10: Operand writes made while `busy` is high are discarded. A later computation uses the operand values from before the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_x | input | 1 | Write strobe for the X operand; with auto-start on, it also starts a computation |
| wr_y | input | 1 | Write strobe for the Y operand |
| wr_z | input | 1 | Write strobe for the Z (angle) operand |
| wr_data | input | 32 | Operand word; the value sits in bits 31:8 |
| start | input | 1 | Explicit start pulse, used when auto-start is off |
| cfg_mode | input | 2 | Function select; only 2'b01 (circular) is run |
| cfg_rotate | input | 1 | 1 = rotation, 0 = vectoring |
| cfg_autostart | input | 1 | 1 = an X write starts a computation |
| res_x | output | 32 | X result, left-justified |
| res_y | output | 32 | Y result, left-justified |
| res_z | output | 32 | Z result, left-justified |
| busy | output | 1 | High while micro-rotations run |
| done | output | 1 | High from completion until the next start |

## Verification
The checker watches the control sequence on every cycle. It covers the exact 24-cycle busy span, `done` rising as `busy` falls and being cleared at start, and results held between completions. It also covers the zero padding byte, the mode gate, the effect of the auto-start setting, and the idle state after reset. Only the bench scenarios can show the arithmetic itself: rotation and vectoring results against real-valued trigonometry, a Park-style rotation with nonzero Y, and the dropping of operand writes made during a busy period.

// File: rtl/rotvec_pkg.sv
package rotvec_pkg;

    localparam int DATA_W   = 24;
    localparam int WORD_W   = 32;
    localparam int PAD_W    = WORD_W - DATA_W;
    localparam int MAX_ITER = 24;
    localparam int IDX_W    = $clog2(MAX_ITER);

    typedef enum logic [1:0] {
        FN_RSVD_A   = 2'b00,
        FN_CIRCULAR = 2'b01,
        FN_RSVD_B   = 2'b10,
        FN_RSVD_C   = 2'b11
    } fn_sel_e;

    typedef logic signed [DATA_W-1:0] sample_t;

    typedef struct packed {
        sample_t x;
        sample_t y;
        sample_t z;
    } vec3_t;

    // Angle of step i, atan(2^-i), scaled so that 2^(DATA_W-1) is pi.
    function automatic sample_t atan_step(input logic [IDX_W-1:0] i);
        case (i)
            5'd0:    return 24'sd2097152;
            5'd1:    return 24'sd1238022;
            5'd2:    return 24'sd654137;
            5'd3:    return 24'sd332050;
            5'd4:    return 24'sd166669;
            5'd5:    return 24'sd83416;
            5'd6:    return 24'sd41718;
            5'd7:    return 24'sd20860;
            5'd8:    return 24'sd10430;
            5'd9:    return 24'sd5215;
            5'd10:   return 24'sd2608;
            5'd11:   return 24'sd1304;
            5'd12:   return 24'sd652;
            5'd13:   return 24'sd326;
            5'd14:   return 24'sd163;
            5'd15:   return 24'sd81;
            5'd16:   return 24'sd41;
            5'd17:   return 24'sd20;
            5'd18:   return 24'sd10;
            5'd19:   return 24'sd5;
            5'd20:   return 24'sd3;
            5'd21:   return 24'sd1;
            5'd22:   return 24'sd1;
            default: return 24'sd0;
        endcase
    endfunction

    function automatic sample_t word_to_sample(input logic [WORD_W-1:0] w);
        return sample_t'(w[WORD_W-1 -: DATA_W]);
    endfunction

    function automatic logic [WORD_W-1:0] sample_to_word(input sample_t s);
        return {s, {PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/rotvec_microrot.sv
module rotvec_microrot
    import rotvec_pkg::*;
(
    input  vec3_t              cur,
    input  logic [IDX_W-1:0]   idx,
    input  logic               rotate,
    output vec3_t              nxt
);

    sample_t x_sh;
    sample_t y_sh;
    sample_t ang;
    logic    ccw;

    always_comb begin
        x_sh = $signed(cur.x) >>> idx;
        y_sh = $signed(cur.y) >>> idx;
        ang  = atan_step(idx);
        // Rotation steers Z to zero, vectoring steers Y to zero.
        ccw  = rotate ? ~cur.z[DATA_W-1] : cur.y[DATA_W-1];
        if (ccw) begin
            nxt.x = cur.x - y_sh;
            nxt.y = cur.y + x_sh;
            nxt.z = cur.z - ang;
        end else begin
            nxt.x = cur.x + y_sh;
            nxt.y = cur.y - x_sh;
            nxt.z = cur.z + ang;
        end
    end

endmodule

// File: rtl/rotvec_launch.sv
module rotvec_launch
    import rotvec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_x,
    input  logic              wr_y,
    input  logic              wr_z,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_autostart,
    input  logic              busy,
    output logic              go,
    output vec3_t             launch
);

    vec3_t   op_q;
    sample_t wr_val;

    assign wr_val = word_to_sample(wr_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else if (!busy) begin
            if (wr_x) op_q.x <= wr_val;
            if (wr_y) op_q.y <= wr_val;
            if (wr_z) op_q.z <= wr_val;
        end
    end

    always_comb begin
        launch = op_q;
        if (wr_x) launch.x = wr_val;
        if (wr_y) launch.y = wr_val;
        if (wr_z) launch.z = wr_val;
        go = !busy && (fn_sel_e'(cfg_mode) == FN_CIRCULAR)
                   && (cfg_autostart ? wr_x : start);
    end

endmodule

// File: rtl/rotvec_cordic.sv
module rotvec_cordic
    import rotvec_pkg::*;
#(
    parameter int ITER = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_x,
    input  logic        wr_y,
    input  logic        wr_z,
    input  logic [31:0] wr_data,
    input  logic        start,
    input  logic [1:0]  cfg_mode,
    input  logic        cfg_rotate,
    input  logic        cfg_autostart,
    output logic [31:0] res_x,
    output logic [31:0] res_y,
    output logic [31:0] res_z,
    output logic        busy,
    output logic        done
);

    localparam logic [IDX_W-1:0] LAST_STEP = IDX_W'(ITER - 1);

    logic             go;
    vec3_t            launch;
    vec3_t            work_q;
    vec3_t            work_nxt;
    vec3_t            res_q;
    logic [IDX_W-1:0] step_q;
    logic             rot_q;
    logic             busy_q;
    logic             done_q;

    rotvec_launch u_launch (
        .clk           (clk),
        .rst           (rst),
        .wr_x          (wr_x),
        .wr_y          (wr_y),
        .wr_z          (wr_z),
        .wr_data       (wr_data),
        .start         (start),
        .cfg_mode      (cfg_mode),
        .cfg_autostart (cfg_autostart),
        .busy          (busy_q),
        .go            (go),
        .launch        (launch)
    );

    rotvec_microrot u_step (
        .cur    (work_q),
        .idx    (step_q),
        .rotate (rot_q),
        .nxt    (work_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            res_q  <= '0;
            step_q <= '0;
            rot_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (go) begin
            work_q <= launch;
            rot_q  <= cfg_rotate;
            step_q <= '0;
            busy_q <= 1'b1;
            done_q <= 1'b0;
        end else if (busy_q) begin
            work_q <= work_nxt;
            step_q <= step_q + 1'b1;
            if (step_q == LAST_STEP) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                res_q  <= work_nxt;
            end
        end
    end

    assign res_x = sample_to_word(res_q.x);
    assign res_y = sample_to_word(res_q.y);
    assign res_z = sample_to_word(res_q.z);
    assign busy  = busy_q;
    assign done  = done_q;

endmodule

// File: rtl/rotvec_cordic_chk.sv
module rotvec_cordic_chk #(
    parameter int ITER = 24
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_x,
    input logic        start,
    input logic [1:0]  cfg_mode,
    input logic        cfg_autostart,
    input logic [31:0] res_x,
    input logic [31:0] res_y,
    input logic [31:0] res_z,
    input logic        busy,
    input logic        done
);

    logic [7:0] span;

    always_ff @(posedge clk) begin
        if (rst)       span <= '0;
        else if (busy) span <= span + 8'd1;
        else           span <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) $past(rst) |-> (!busy && !done && res_x == '0 && res_y == '0 && res_z == '0)); // R1
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst) (res_x[7:0] == 8'h00 && res_y[7:0] == 8'h00 && res_z[7:0] == 8'h00)); // R2
    AST_AUTO_LAUNCH: assert property (@(posedge clk) disable iff (rst) (!busy && cfg_autostart && cfg_mode == 2'b01 && wr_x) |=> busy); // R3
    AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst) (!busy && !cfg_autostart && !start) |=> !busy); // R4
    AST_MODE_GATE: assert property (@(posedge clk) disable iff (rst) (!busy && cfg_mode != 2'b01) |=> !busy); // R5
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (span == 8'(ITER))); // R8
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (rst) busy |-> (span < 8'(ITER))); // R8
    AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R9
    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> !done); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && !$past(busy)) |-> ($stable(res_x) && $stable(res_y) && $stable(res_z))); // R9

endmodule

bind rotvec_cordic rotvec_cordic_chk #(.ITER(ITER)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_x          (wr_x),
    .start         (start),
    .cfg_mode      (cfg_mode),
    .cfg_autostart (cfg_autostart),
    .res_x         (res_x),
    .res_y         (res_y),
    .res_z         (res_z),
    .busy          (busy),
    .done          (done)
);

// File: tb/rotvec_cordic_test.sv
module rotvec_cordic_test;

    localparam int  CLK_PERIOD = 10;
    localparam int  NV         = 7;
    localparam real K_GAIN     = 1.6467602581;
    localparam real FS         = 8388608.0;
    localparam real PI_R       = 3.14159265358979;
    localparam real TOL        = 128.0;

    // {rotate, x, y, z}
    localparam logic [72:0] VECS [NV] = '{
        {1'b1, 24'sd5000000, 24'sd0,       24'sd1398101},
        {1'b1, 24'sd5000000, 24'sd0,       -24'sd2097152},
        {1'b1, 24'sd5000000, 24'sd0,       24'sd4194304},
        {1'b1, 24'sd2000000, 24'sd3000000, -24'sd2097152},
        {1'b0, 24'sd3000000, 24'sd4000000, 24'sd0},
        {1'b0, 24'sd4000000, -24'sd2000000, 24'sd0},
        {1'b0, 24'sd2500000, 24'sd2500000, 24'sd100000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_x = 1'b0, wr_y = 1'b0, wr_z = 1'b0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic [1:0]  cfg_mode = 2'b01;
    logic        cfg_rotate = 1'b1;
    logic        cfg_autostart = 1'b1;
    logic [31:0] res_x, res_y, res_z;
    logic        busy, done;

    int n_total = 0;
    int n_fail  = 0;

    rotvec_cordic uut (
        .clk(clk), .rst(rst), .wr_x(wr_x), .wr_y(wr_y), .wr_z(wr_z),
        .wr_data(wr_data), .start(start), .cfg_mode(cfg_mode),
        .cfg_rotate(cfg_rotate), .cfg_autostart(cfg_autostart),
        .res_x(res_x), .res_y(res_y), .res_z(res_z), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.1f expected %0.1f", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input string what,
                              input logic [31:0] word, input real exp);
        real act;
        act = $itor($signed(word[31:8]));
        check((act - exp <= TOL) && (exp - act <= TOL), req, what, act, exp);
    endtask

    task automatic write_op(input int sel, input logic signed [23:0] v);
        @(negedge clk);
        wr_data = {v, 8'h5A};
        wr_x = (sel == 0); wr_y = (sel == 1); wr_z = (sel == 2);
        @(negedge clk);
        wr_x = 1'b0; wr_y = 1'b0; wr_z = 1'b0;
    endtask

    task automatic wait_done(output int cycles);
        cycles = 1;
        while (!done && cycles < 200) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic expect_calc(input logic [72:0] v, output real ex,
                               output real ey, output real ez);
        logic signed [23:0] xs, ys, zs;
        real xr, yr, zr, th;
        xs = v[71:48]; ys = v[47:24]; zs = v[23:0];
        xr = $itor(xs); yr = $itor(ys); zr = $itor(zs);
        if (v[72]) begin
            th = zr * PI_R / FS;
            ex = K_GAIN * (xr * $cos(th) - yr * $sin(th));
            ey = K_GAIN * (xr * $sin(th) + yr * $cos(th));
            ez = 0.0;
        end else begin
            ex = K_GAIN * $sqrt(xr * xr + yr * yr);
            ey = 0.0;
            ez = zr + $atan2(yr, xr) * FS / PI_R;
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 50000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin : main
        int          cyc;
        real         ex, ey, ez;
        logic [31:0] keep_x, keep_y, keep_z;

        repeat (5) @(negedge clk);
        check(!busy && !done && res_x == 0 && res_y == 0 && res_z == 0,
              "R1", "idle after reset", real'(busy), 0.0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R1", "idle after release", real'(done), 0.0);

        // Vector table: R6 rotation, R7 vectoring, R2 layout, R3 auto-start
        for (int i = 0; i < NV; i++) begin
            cfg_rotate = VECS[i][72];
            write_op(1, VECS[i][47:24]);
            write_op(2, VECS[i][23:0]);
            write_op(0, VECS[i][71:48]);
            check(busy && !done, "R3", "auto-start on X write", real'(busy), 1.0);
            wait_done(cyc);
            expect_calc(VECS[i], ex, ey, ez);
            check_near(VECS[i][72] ? "R6" : "R7", $sformatf("vec%0d X", i), res_x, ex);
            check_near(VECS[i][72] ? "R6" : "R7", $sformatf("vec%0d Y", i), res_y, ey);
            check_near(VECS[i][72] ? "R6" : "R7", $sformatf("vec%0d Z", i), res_z, ez);
            check(res_x[7:0] == 0 && res_y[7:0] == 0 && res_z[7:0] == 0,
                  "R2", "pad byte zero", real'(res_x[7:0]), 0.0);
        end

        // R10: writes during busy are dropped; rerun gives identical results
        cfg_rotate = 1'b1;
        write_op(1, 24'sd0);
        write_op(2, 24'sd1398101);
        write_op(0, 24'sd5000000);
        write_op(1, 24'sd3000000);
        write_op(2, 24'sd0);
        wait_done(cyc);
        keep_x = res_x; keep_y = res_y; keep_z = res_z;
        write_op(0, 24'sd5000000);
        wait_done(cyc);
        check(res_x == keep_x && res_y == keep_y && res_z == keep_z,
              "R10", "busy writes ignored", real'($signed(res_y[31:8])),
              real'($signed(keep_y[31:8])));

        // R4: manual start; X write alone does nothing
        cfg_autostart = 1'b0;
        write_op(2, -24'sd2097152);
        write_op(0, 24'sd5000000);
        repeat (3) @(negedge clk);
        check(!busy && done && res_y == keep_y, "R4", "X write without start",
              real'(busy), 0.0);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (cyc == 1)
                check(!done && busy, "R9", "done cleared at start", real'(done), 0.0);
        end while (!done && cyc < 100);
        check(cyc == 24, "R8", "start to done latency", real'(cyc), 24.0);
        expect_calc(VECS[1], ex, ey, ez);
        check_near("R4", "manual start X", res_x, ex);
        check_near("R4", "manual start Y", res_y, ey);
        keep_x = res_x; keep_y = res_y; keep_z = res_z;
        repeat (5) @(negedge clk);
        check(done && res_x == keep_x && res_z == keep_z, "R9", "done and results held",
              real'(done), 1.0);

        // R5: non-circular mode does not start
        cfg_autostart = 1'b1;
        cfg_mode = 2'b10;
        write_op(0, 24'sd1000000);
        repeat (2) @(negedge clk);
        check(!busy && res_x == keep_x, "R5", "mode gate auto", real'(busy), 0.0);
        cfg_autostart = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(!busy && res_x == keep_x, "R5", "mode gate manual", real'(busy), 0.0);

        // R1: reset in the middle of a computation
        cfg_mode = 2'b01;
        cfg_autostart = 1'b1;
        write_op(0, 24'sd5000000);
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!busy && !done && res_x == 0 && res_z == 0, "R1", "reset mid-run",
              real'(busy), 0.0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule